// File: doc/BRIEF.md
# Identification-Code Command Gate

This block sits between a byte-wide receive port, fed by an external programming tool, and the controller of an on-chip non-volatile memory. Every byte that is not part of an identification frame is read as a one-byte command code. The gate decides whether each command may pass to the memory controller. Commands are forwarded only when access is open. Access is open when the memory reports that it is blank, or when the tool has sent a 7-byte identification code that matches the stored code.

An identification frame is the opcode 0xF5 followed by seven code bytes. The code bytes are compared one at a time in a fixed order. A wrong byte marks the frame as failed, but all seven bytes are still consumed, so the stream stays aligned. A match opens access until the next reset.

On top of this gate, programming and erasing aimed at the protected boot region are always refused, even when access is open. A refused command raises a one-cycle reject pulse and a sticky status bit, and it is never forwarded.

Both the receive side and the command side are valid/ready streams. A byte moves when `rx_valid && rx_ready`. A command moves when `cmd_valid && cmd_ready`. While a forwarded command waits for `cmd_ready`, `rx_ready` is low. The waiting byte must then be held stable by the sender, and the gate does not look at it. `cmd_valid` and `cmd_op` stay stable until the command is taken.

Top module: `cmd_id_gate`

## Requirements
- R1: After reset, `status` is 0, `unlocked` is 0, `cmd_valid` is 0, `cmd_reject` is 0 and `rx_ready` is 1.
- R2: With `mem_blank` low and access not unlocked, every command byte other than 0xF5 is refused. `cmd_reject` is high for exactly the cycle after the byte is taken, status bit2 is set, and `cmd_valid` stays low.
- R3: With `mem_blank` high, the known commands 0x41 (program), 0x20 (erase), 0xFF (read) and 0x70 (status read) are forwarded without any identification.
- R4: Opcode 0xF5 starts a frame of 7 code bytes. Frame byte k is compared with `stored_id[8k+7:8k]`, for k from 0 to 6. If all seven match, `unlocked` and status bit0 go high in the cycle after the seventh byte is taken.
- R5: Any mismatching frame byte sets status bit1 from the cycle after that byte, and unlocking is not granted. The remaining frame bytes are still consumed, so the byte after the seventh is decoded as a command. Bit1 is cleared when a new frame opcode is taken.
- R6: Once unlocked, the gate stays unlocked until reset, including through a later failed frame.
- R7: Program (0x41) and erase (0x20) taken with `tgt_boot` high are refused even when access is open. Read (0xFF) and status read (0x70) with `tgt_boot` high are forwarded when access is open. `tgt_boot` is sampled with the command byte.
- R8: Any byte other than 0x41, 0x20, 0xFF, 0x70 and 0xF5, when taken as a command, is refused, whatever the access state.
- R9: A forwarded command appears as `cmd_valid` with `cmd_op` equal to the byte, in the cycle after that byte is taken. It holds stable until `cmd_ready` is high, and `cmd_accept` equals `cmd_valid && cmd_ready`. `rx_ready` is low while the command waits. Forwarding clears status bit2.
- R10: Status bit3 (busy) is high while a frame is being collected or a forwarded command is waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte is valid |
| rx_ready | output | 1 | Gate can take a byte |
| mem_blank | input | 1 | Memory holds no data |
| stored_id | input | 56 | Stored identification code, byte k at bits 8k+7:8k |
| tgt_boot | input | 1 | Decoded target of the command lies in the boot region |
| cmd_valid | output | 1 | Forwarded command is waiting |
| cmd_op | output | 8 | Forwarded command code |
| cmd_ready | input | 1 | Memory controller takes the command |
| cmd_accept | output | 1 | Command handed over this cycle |
| cmd_reject | output | 1 | One-cycle pulse: last command byte was refused |
| unlocked | output | 1 | Identification matched |
| status | output | 4 | bit0 unlocked, bit1 mismatch seen, bit2 last command refused, bit3 busy |

## Verification
Two functions can fall in the same cycle: handing a waiting command to the memory controller, and a new byte offered on the receive side. The bench keeps `cmd_ready` low while a second byte is held valid for several cycles. It checks that `rx_ready`, `cmd_op` and `cmd_reject` stay still. It then raises `cmd_ready`, expects `cmd_accept` in that cycle with the byte still not taken, and expects the byte to be decoded one cycle later. Random traffic with random stall lengths repeats this overlap, and it is judged against a requirement-level model of the lock, mismatch and reject state.

// File: rtl/idgate_pkg.sv
package idgate_pkg;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_PROGRAM = 8'h41;
  localparam logic [7:0] OP_STATUS  = 8'h70;
  localparam logic [7:0] OP_UNLOCK  = 8'hF5;
  localparam logic [7:0] OP_READ    = 8'hFF;

  typedef enum logic [1:0] {
    DEC_REJECT  = 2'd0,
    DEC_FORWARD = 2'd1,
    DEC_UNLOCK  = 2'd2
  } dec_e;
endpackage

// File: rtl/idg_id_compare.sv
module idg_id_compare #(
  parameter int ID_BYTES = 7,
  parameter int BYTE_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       byte_fire,
  input  logic [BYTE_W-1:0]          byte_in,
  input  logic [ID_BYTES*BYTE_W-1:0] ref_id,
  output logic                       collecting,
  output logic                       unlocked,
  output logic                       mismatch
);
  localparam int IDX_W = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ID_BYTES - 1);

  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] ref_byte;
  logic              byte_bad;

  always_comb begin
    ref_byte = ref_id[int'(idx)*BYTE_W +: BYTE_W];
    byte_bad = (byte_in != ref_byte);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      collecting <= 1'b0;
      unlocked   <= 1'b0;
      mismatch   <= 1'b0;
      idx        <= '0;
    end else if (start) begin
      collecting <= 1'b1;
      mismatch   <= 1'b0;
      idx        <= '0;
    end else if (collecting && byte_fire) begin
      if (byte_bad) mismatch <= 1'b1;
      if (idx == LAST) begin
        collecting <= 1'b0;
        idx        <= '0;
        if (!byte_bad && !mismatch) unlocked <= 1'b1;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  AST_UNLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked |=> unlocked); // R6
  AST_UNLOCK_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(collecting) && !mismatch); // R4
  AST_MISMATCH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (collecting && mismatch && !unlocked) |=> !unlocked); // R5
endmodule

// File: rtl/idg_decide.sv
module idg_decide
  import idgate_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] op,
  input  logic              to_boot,
  input  logic              access_ok,
  output dec_e              dec
);
  always_comb begin
    case (op)
      OP_UNLOCK:           dec = DEC_UNLOCK;
      OP_PROGRAM,
      OP_ERASE:            dec = (access_ok && !to_boot) ? DEC_FORWARD : DEC_REJECT;
      OP_READ,
      OP_STATUS:           dec = access_ok ? DEC_FORWARD : DEC_REJECT;
      default:             dec = DEC_REJECT;
    endcase
  end
endmodule

// File: rtl/idg_cmd_hold.sv
module idg_cmd_hold
  import idgate_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] op_in,
  input  logic              boot_in,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_op
);
  logic held_boot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_op    <= '0;
      held_boot <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_op    <= op_in;
      held_boot <= boot_in;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_op)); // R9
  AST_NO_BOOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(held_boot && (out_op == OP_PROGRAM || out_op == OP_ERASE))); // R7
endmodule

// File: rtl/cmd_id_gate.sv
module cmd_id_gate
  import idgate_pkg::*;
#(
  parameter int ID_BYTES = 7,
  parameter int BYTE_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [BYTE_W-1:0]          rx_data,
  input  logic                       rx_valid,
  output logic                       rx_ready,
  input  logic                       mem_blank,
  input  logic [ID_BYTES*BYTE_W-1:0] stored_id,
  input  logic                       tgt_boot,
  output logic                       cmd_valid,
  output logic [BYTE_W-1:0]          cmd_op,
  input  logic                       cmd_ready,
  output logic                       cmd_accept,
  output logic                       cmd_reject,
  output logic                       unlocked,
  output logic [3:0]                 status
);
  logic fire, collecting, mismatch, unlocked_i;
  logic op_byte, start, load, rej_now, rej_flag;
  dec_e dec;

  assign rx_ready   = !cmd_valid;
  assign fire       = rx_valid && rx_ready;
  assign op_byte    = fire && !collecting;
  assign start      = op_byte && (dec == DEC_UNLOCK);
  assign load       = op_byte && (dec == DEC_FORWARD);
  assign rej_now    = op_byte && (dec == DEC_REJECT);
  assign cmd_accept = cmd_valid && cmd_ready;
  assign unlocked   = unlocked_i;
  assign status     = {collecting || cmd_valid, rej_flag, mismatch, unlocked_i};

  idg_decide #(.BYTE_W(BYTE_W)) u_decide (
    .op        (rx_data),
    .to_boot   (tgt_boot),
    .access_ok (unlocked_i || mem_blank),
    .dec       (dec)
  );

  idg_id_compare #(.ID_BYTES(ID_BYTES), .BYTE_W(BYTE_W)) u_idcmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .byte_fire  (fire),
    .byte_in    (rx_data),
    .ref_id     (stored_id),
    .collecting (collecting),
    .unlocked   (unlocked_i),
    .mismatch   (mismatch)
  );

  idg_cmd_hold #(.BYTE_W(BYTE_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .op_in     (rx_data),
    .boot_in   (tgt_boot),
    .out_ready (cmd_ready),
    .out_valid (cmd_valid),
    .out_op    (cmd_op)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_reject <= 1'b0;
      rej_flag   <= 1'b0;
    end else begin
      cmd_reject <= rej_now;
      if (rej_now)   rej_flag <= 1'b1;
      else if (load) rej_flag <= 1'b0;
    end
  end

  AST_LOCKED_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> $past(unlocked_i || mem_blank)); // R2
  AST_REJECT_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |-> !$rose(cmd_valid) && rej_flag); // R2
  AST_BUSY_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> status[3] && !rx_ready); // R10
endmodule

// File: tb/cmd_id_gate_tb.sv
module cmd_id_gate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic        mem_blank = 1'b0;
  logic [55:0] stored_id;
  logic        tgt_boot = 1'b0;
  logic        cmd_valid;
  logic [7:0]  cmd_op;
  logic        cmd_ready = 1'b0;
  logic        cmd_accept, cmd_reject, unlocked;
  logic [3:0]  status;

  int checks = 0;
  int errors = 0;
  bit m_unl, m_mis, m_rej, m_col;
  int m_idx;

  always #10 clk = ~clk;

  cmd_id_gate u_dut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .mem_blank(mem_blank), .stored_id(stored_id),
    .tgt_boot(tgt_boot), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ready(cmd_ready), .cmd_accept(cmd_accept), .cmd_reject(cmd_reject),
    .unlocked(unlocked), .status(status)
  );

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // 0 refuse, 1 forward, 2 frame start
  function automatic int decide(logic [7:0] op, bit boot, bit acc);
    if (op == 8'hF5) return 2;
    if (op == 8'h41 || op == 8'h20) return (acc && !boot) ? 1 : 0;
    if (op == 8'hFF || op == 8'h70) return acc ? 1 : 0;
    return 0;
  endfunction

  function automatic string tag_of(logic [7:0] op, bit boot, bit acc);
    if (!(op == 8'h41 || op == 8'h20 || op == 8'hFF || op == 8'h70)) return "R8";
    if (!acc) return "R2";
    if (boot && (op == 8'h41 || op == 8'h20)) return "R7";
    if (mem_blank && !m_unl) return "R3";
    return "R9";
  endfunction

  function automatic logic [7:0] id_byte(int k);
    return stored_id[k*8 +: 8];
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; rx_valid = 1'b0; cmd_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_unl = 0; m_mis = 0; m_rej = 0; m_col = 0; m_idx = 0;
    @(negedge clk);
    chk(status == 4'h0, "R1 status", status, 0);
    chk(!unlocked && !cmd_valid && !cmd_reject, "R1 outputs",
        {unlocked, cmd_valid, cmd_reject}, 0);
    chk(rx_ready == 1'b1, "R1 rx_ready", rx_ready, 1);
  endtask

  // called at a negedge with no command waiting
  task automatic put(logic [7:0] b, bit boot, int stall);
    bit fwd, rej;
    string tag;
    int d;
    fwd = 0; rej = 0;
    rx_data = b; rx_valid = 1'b1; tgt_boot = boot;
    chk(rx_ready == 1'b1, "R9 ready idle", rx_ready, 1);
    if (m_col) begin
      tag = m_mis ? "R5" : "R4";
      if (b != id_byte(m_idx)) begin m_mis = 1; tag = "R5"; end
      m_idx++;
      if (m_idx == 7) begin
        m_col = 0;
        if (!m_mis) m_unl = 1;
      end
    end else begin
      tag = tag_of(b, boot, m_unl || mem_blank);
      d = decide(b, boot, m_unl || mem_blank);
      if (d == 2) begin m_col = 1; m_idx = 0; m_mis = 0; tag = "R5"; end
      else if (d == 1) begin fwd = 1; m_rej = 0; end
      else begin rej = 1; m_rej = 1; end
    end
    @(negedge clk);
    rx_valid = 1'b0;
    chk(cmd_reject == rej, tag, cmd_reject, rej);
    chk(cmd_valid == fwd, tag, cmd_valid, fwd);
    if (fwd) chk(cmd_op == b, "R9 op", cmd_op, b);
    chk(status == {m_col || fwd, m_rej, m_mis, m_unl}, tag, status,
        {m_col || fwd, m_rej, m_mis, m_unl});
    chk(unlocked == m_unl, (m_unl ? "R6" : "R4"), unlocked, m_unl);
    if (fwd) begin
      for (int i = 0; i < stall; i++) begin
        @(negedge clk);
        chk(cmd_valid && cmd_op == b && !rx_ready && status[3],
            "R10 held", {cmd_valid, rx_ready, status[3]}, 3'b101);
      end
      cmd_ready = 1'b1;
      #1;
      chk(cmd_accept == 1'b1, "R9 accept", cmd_accept, 1);
      @(negedge clk);
      cmd_ready = 1'b0;
      chk(!cmd_valid && rx_ready && !status[3], "R9 drained",
          {cmd_valid, rx_ready, status[3]}, 3'b010);
    end
  endtask

  task automatic frame(int bad_pos);
    put(8'hF5, 1'b0, 0);
    chk(status[3] == 1'b1, "R10 collecting", status[3], 1);
    for (int k = 0; k < 7; k++)
      put((k == bad_pos) ? (id_byte(k) ^ 8'h5A) : id_byte(k), 1'b0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D6A7E));
    stored_id = {$urandom, $urandom};
    do_reset();

    // locked, data present
    mem_blank = 1'b0;
    put(8'h41, 1'b0, 0);                     // R2
    put(8'h70, 1'b0, 0);                     // R2
    // blank memory waives the code
    mem_blank = 1'b1;
    put(8'h41, 1'b0, 1);                     // R3
    put(8'h20, 1'b1, 0);                     // R7 boot erase refused
    put(8'hFF, 1'b1, 0);                     // R7 boot read allowed
    put(8'h3C, 1'b0, 0);                     // R8
    // wrong code byte 3, framing kept
    mem_blank = 1'b0;
    frame(3);                                // R5
    put(8'h41, 1'b0, 0);                     // R5: decoded as command, refused
    frame(-1);                               // R4
    put(8'h41, 1'b0, 2);                     // R9
    frame(6);                                // R6 stays unlocked
    put(8'h20, 1'b0, 0);

    // overlap: waiting command and a new byte offered
    rx_data = 8'h70; rx_valid = 1'b1; tgt_boot = 1'b0;
    @(negedge clk);
    rx_valid = 1'b0; m_rej = 0;
    chk(cmd_valid && cmd_op == 8'h70, "R9 overlap load", cmd_op, 8'h70);
    rx_data = 8'h20; rx_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!rx_ready && cmd_op == 8'h70 && !cmd_reject, "R9 backpressure",
          {rx_ready, cmd_reject}, 0);
    end
    cmd_ready = 1'b1;
    #1;
    chk(cmd_accept && !rx_ready, "R9 accept with byte waiting",
        {cmd_accept, rx_ready}, 2'b10);
    @(negedge clk);
    cmd_ready = 1'b0;
    chk(!cmd_valid && rx_ready, "R9 byte not taken early",
        {cmd_valid, rx_ready}, 2'b01);
    put(8'h20, 1'b0, 0);

    // random traffic
    for (int it = 0; it < 400; it++) begin
      int sel;
      if (it == 200) do_reset();
      if ($urandom % 8 == 0) mem_blank = $urandom % 2;
      sel = $urandom % 7;
      case (sel)
        0: put(8'h41, $urandom % 2, $urandom % 3);
        1: put(8'h20, $urandom % 2, $urandom % 3);
        2: put(8'hFF, $urandom % 2, $urandom % 3);
        3: put(8'h70, $urandom % 2, $urandom % 3);
        4: put(8'h00 + 8'($urandom % 16), $urandom % 2, 0);
        default: frame(($urandom % 3 == 0) ? int'($urandom % 7) : -1);
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule